// File: doc/BRIEF.md
# Frame Sequencer with Interrupt Register

This block runs a programmed number of panel frames for one display update and reports its progress through one combined interrupt register. A timing generator elsewhere supplies a one-cycle pulse at the end of each panel frame and a one-cycle pulse per panel line. The sequencer counts these pulses while a sequence is running and turns them into four interrupt events: frame end, display end, a marked frame and a line flag.

Software reaches the block through a simple single-cycle write port and a combinational read port. The frame count, the marked-frame index and the flag line are written into shadow registers. A write to the commit register copies all shadow values into the active copy in one cycle. A sequence is launched only by a 0-to-1 transition of the go bit. The interrupt register holds sticky status bits, mask bits and write-one clear strobes. The single interrupt output is high whenever an unmasked status bit is set.

Top module: `fseq_top`

## Requirements
- R1: After reset `busy` and `irq` are 0, all four status bits are 0, all four mask bits are 1 (the interrupt register reads 0x0F0), and the shadow frame and line registers and the go bit read 0.
- R2: Register map (word addresses): 0 = go bit in bit 0; 1 = shadow frame register with the frame count minus one in bits [7:0] and the marked-frame index in bits [15:8]; 2 = shadow flag line in bits [11:0]; 3 = interrupt register; 4 = commit when bit 0 of the write is 1. Shadow writes read back at once but have no effect on sequencing until a commit copies all of them to the active copy in the same cycle.
- R3: A write to address 0 with bit 0 = 1 while the stored go bit is 0 starts a sequence, and `busy` is 1 from the next cycle. A write of 1 while the go bit is already 1 starts nothing.
- R4: A start request made while `busy` is 1 is ignored. The running sequence keeps its frame count.
- R5: A sequence lasts N+1 frames, where N is the active frame count minus one. `busy` falls in the cycle after the `frame_end` pulse that ends frame N+1.
- R6: Status bit 0 (frame end) is set by every `frame_end` pulse while `busy` is 1.
- R7: Status bit 1 (display end) is set by the `frame_end` pulse that completes the last frame of the sequence.
- R8: Status bit 2 (marked frame) is set by the `frame_end` pulse of the frame whose zero-based index equals the active marked-frame index.
- R9: Status bit 3 (line flag) is set by a `line_pulse` whose zero-based line index within the frame equals the active flag line. The line index restarts at 0 at sequence start and after each `frame_end`.
- R10: A write to address 3 loads the mask bits from bits [7:4] and clears every status bit whose bit in [11:8] is 1. The clear field reads back as 0. A clear in the same cycle as a new event on that bit leaves the bit set.
- R11: `irq` is 1 exactly when at least one status bit is set and its mask bit is 0.
- R12: `frame_end` and `line_pulse` while `busy` is 0 set no status bit and change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| frame_end | input | 1 | One-cycle pulse at the end of each panel frame |
| line_pulse | input | 1 | One-cycle pulse per panel line |
| busy | output | 1 | A frame sequence is running |
| irq | output | 1 | Interrupt, OR of the unmasked status bits |

## Verification
The assertions assume that `frame_end` and `line_pulse` are single-cycle pulses that never fall in the same cycle, and that neither of them coincides with the cycle in which a start request is accepted. The bench drives every pulse as an isolated high cycle with a low cycle after it, and it issues register writes only between pulses. The one exception is the deliberate case of a clear written in the same cycle as a frame-end event. A behavioural model updated on every clock predicts `busy`, `irq` and the read port, and the bench compares them on every cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    parameter int FCNT_W = 8;
    parameter int LINE_W = 12;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 3;
    parameter int NUM_EV = 4;

    localparam int EV_FEND = 0;
    localparam int EV_DEND = 1;
    localparam int EV_DFRM = 2;
    localparam int EV_LINE = 3;
    localparam int MASK_LSB = NUM_EV;
    localparam int CLR_LSB  = 2 * NUM_EV;

    typedef enum logic [ADDR_W-1:0] {
        A_GO     = 3'd0,
        A_FRAME  = 3'd1,
        A_LINE   = 3'd2,
        A_IRQ    = 3'd3,
        A_COMMIT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [LINE_W-1:0] flag_line;
        logic [FCNT_W-1:0] mark_idx;
        logic [FCNT_W-1:0] last_idx;
    } seq_cfg_t;

    function automatic logic addr_is(input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return a == r;
    endfunction
endpackage

// File: rtl/fseq_regs.sv
module fseq_regs
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NUM_EV-1:0] status,
    input  logic [NUM_EV-1:0] mask,
    output logic              start_req,
    output logic              irq_we,
    output seq_cfg_t          active,
    output logic [DATA_W-1:0] rd_data
);
    seq_cfg_t shadow;
    logic     go_q;
    logic     wr_go, wr_frame, wr_line, commit;
    logic     unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:2*FCNT_W];

    always_comb begin
        wr_go     = wr_en && addr_is(wr_addr, A_GO);
        wr_frame  = wr_en && addr_is(wr_addr, A_FRAME);
        wr_line   = wr_en && addr_is(wr_addr, A_LINE);
        irq_we    = wr_en && addr_is(wr_addr, A_IRQ);
        commit    = wr_en && addr_is(wr_addr, A_COMMIT) && wr_data[0];
        start_req = wr_go && wr_data[0] && !go_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            shadow <= '0;
            active <= '0;
        end else begin
            if (commit) active <= shadow;
            if (wr_go) go_q <= wr_data[0];
            if (wr_frame) begin
                shadow.last_idx <= wr_data[FCNT_W-1:0];
                shadow.mark_idx <= wr_data[2*FCNT_W-1:FCNT_W];
            end
            if (wr_line) shadow.flag_line <= wr_data[LINE_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_GO:    rd_data[0] = go_q;
            A_FRAME: rd_data[2*FCNT_W-1:0] = {shadow.mark_idx, shadow.last_idx};
            A_LINE:  rd_data[LINE_W-1:0] = shadow.flag_line;
            A_IRQ:   rd_data[2*NUM_EV-1:0] = {mask, status};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  seq_cfg_t          cfg,
    input  logic              frame_end,
    input  logic              line_pulse,
    output logic              busy,
    output logic [NUM_EV-1:0] ev
);
    logic              run;
    logic [FCNT_W-1:0] fcnt;
    logic [LINE_W-1:0] lcnt;
    logic              fstep, at_last;

    always_comb begin
        fstep       = run && frame_end;
        at_last     = fcnt == cfg.last_idx;
        ev          = '0;
        ev[EV_FEND] = fstep;
        ev[EV_DEND] = fstep && at_last;
        ev[EV_DFRM] = fstep && (fcnt == cfg.mark_idx);
        ev[EV_LINE] = run && line_pulse && (lcnt == cfg.flag_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            fcnt <= '0;
            lcnt <= '0;
        end else if (!run) begin
            if (start_req) begin
                run  <= 1'b1;
                fcnt <= '0;
                lcnt <= '0;
            end
        end else if (frame_end) begin
            fcnt <= fcnt + 1'b1;
            lcnt <= '0;
            if (at_last) run <= 1'b0;
        end else if (line_pulse) begin
            lcnt <= lcnt + 1'b1;
        end
    end

    assign busy = run;
endmodule

// File: rtl/fseq_irq.sv
module fseq_irq
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic              irq_we,
    input  logic [NUM_EV-1:0] wr_mask,
    input  logic [NUM_EV-1:0] wr_clr,
    output logic [NUM_EV-1:0] status,
    output logic [NUM_EV-1:0] mask,
    output logic              irq
);
    for (genvar g = 0; g < NUM_EV; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status[g] <= 1'b0;
                mask[g]   <= 1'b1;
            end else begin
                status[g] <= (status[g] && !(irq_we && wr_clr[g])) || ev[g];
                if (irq_we) mask[g] <= wr_mask[g];
            end
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    input  logic              line_pulse,
    output logic              busy,
    output logic              irq
);
    seq_cfg_t          act_cfg;
    logic              start_req, irq_we;
    logic [NUM_EV-1:0] ev_w, st_w, mask_w;

    fseq_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .status(st_w), .mask(mask_w), .start_req(start_req),
        .irq_we(irq_we), .active(act_cfg), .rd_data(rd_data)
    );

    fseq_engine u_engine (
        .clk(clk), .rst(rst), .start_req(start_req), .cfg(act_cfg),
        .frame_end(frame_end), .line_pulse(line_pulse), .busy(busy), .ev(ev_w)
    );

    fseq_irq u_irq (
        .clk(clk), .rst(rst), .ev(ev_w), .irq_we(irq_we),
        .wr_mask(wr_data[MASK_LSB +: NUM_EV]), .wr_clr(wr_data[CLR_LSB +: NUM_EV]),
        .status(st_w), .mask(mask_w), .irq(irq)
    );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk
    import fseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              frame_end,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NUM_EV-1:0] status,
    input logic              irq
);
    // R3
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && wr_addr == 3'd0 && wr_data[0]));
    // R5
    end_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(frame_end));
    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status[EV_DEND]);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[EV_FEND]) |-> $past(busy));
    // R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == 3'd3 && wr_data[CLR_LSB] && !frame_end) |-> !status[EV_FEND]);
    // R11
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));
endmodule

bind fseq_top fseq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .frame_end(frame_end), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(st_w), .irq(irq)
);

// File: tb/fseq_top_test.sv
module fseq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd3;
    logic [31:0] rd_data;
    logic        frame_end = 1'b0;
    logic        line_pulse = 1'b0;
    logic        busy, irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fseq_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_end(frame_end),
        .line_pulse(line_pulse), .busy(busy), .irq(irq)
    );

    // behavioural model
    int m_go, m_run, m_fc, m_lc, m_st, m_mask;
    int s_tot, s_idx, s_line, a_tot, a_idx, a_line;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_go = 0; m_run = 0; m_fc = 0; m_lc = 0; m_st = 0; m_mask = 15;
            s_tot = 0; s_idx = 0; s_line = 0; a_tot = 0; a_idx = 0; a_line = 0;
        end else begin
            int ev;
            bit start;
            ev = 0;
            if (m_run != 0 && frame_end) begin
                ev |= 1;
                if (m_fc == a_tot) ev |= 2;
                if (m_fc == a_idx) ev |= 4;
            end
            if (m_run != 0 && line_pulse && m_lc == a_line) ev |= 8;
            start = wr_en && wr_addr == 0 && wr_data[0] && m_go == 0;
            if (wr_en && wr_addr == 0) m_go = wr_data[0];
            if (wr_en && wr_addr == 3) begin
                m_st = m_st & ~int'(wr_data[11:8]);
                m_mask = int'(wr_data[7:4]);
            end
            m_st = m_st | ev;
            if (m_run == 0) begin
                if (start) begin m_run = 1; m_fc = 0; m_lc = 0; end
            end else if (frame_end) begin
                if (m_fc == a_tot) m_run = 0;
                m_fc = (m_fc + 1) % 256;
                m_lc = 0;
            end else if (line_pulse) begin
                m_lc = (m_lc + 1) % 4096;
            end
            if (wr_en && wr_addr == 4 && wr_data[0]) begin
                a_tot = s_tot; a_idx = s_idx; a_line = s_line;
            end
            if (wr_en && wr_addr == 1) begin
                s_tot = int'(wr_data[7:0]); s_idx = int'(wr_data[15:8]);
            end
            if (wr_en && wr_addr == 2) s_line = int'(wr_data[11:0]);
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_run[0], "R5", "busy", busy, m_run);
            chk(irq == ((m_st & ~m_mask & 15) != 0), "R11", "irq", irq, (m_st & ~m_mask & 15) != 0);
            case (rd_addr)
                3'd3: begin
                    chk(rd_data[0] == m_st[0], "R6", "frame end bit", rd_data[0], m_st[0]);
                    chk(rd_data[1] == m_st[1], "R7", "display end bit", rd_data[1], m_st[1]);
                    chk(rd_data[2] == m_st[2], "R8", "marked frame bit", rd_data[2], m_st[2]);
                    chk(rd_data[3] == m_st[3], "R9", "line flag bit", rd_data[3], m_st[3]);
                    chk(int'(rd_data[7:4]) == m_mask, "R11", "mask", rd_data[7:4], m_mask);
                    chk(rd_data[31:8] == 0, "R10", "clear field readback", rd_data[31:8], 0);
                end
                3'd1: chk(rd_data == 32'((s_idx << 8) | s_tot), "R2", "frame shadow", rd_data, (s_idx << 8) | s_tot);
                3'd2: chk(rd_data == 32'(s_line), "R2", "line shadow", rd_data, s_line);
                3'd0: chk(rd_data == 32'(m_go), "R3", "go bit", rd_data, m_go);
                default: ;
            endcase
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic frame(input int lines);
        for (int i = 0; i < lines; i++) begin
            line_pulse = 1'b1; @(negedge clk);
            line_pulse = 1'b0; @(negedge clk);
        end
        frame_end = 1'b1; @(negedge clk);
        frame_end = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(rd_data == 32'h0F0, "R1", "irq register after reset", rd_data, 32'h0F0);
        rd_addr = 3'd1; #1;
        chk(rd_data == 0, "R1", "frame shadow after reset", rd_data, 0);
        rd_addr = 3'd3;

        // R2 shadow written without commit: active count stays at one frame
        wr(1, 32'h0102);
        wr(2, 2);
        rd_addr = 3'd1; #1;
        chk(rd_data == 32'h0102, "R2", "shadow readback", rd_data, 32'h0102);
        rd_addr = 3'd3;
        wr(0, 1);
        chk(busy == 1'b1, "R3", "start on go rise", busy, 1);
        frame(3);
        chk(busy == 1'b0, "R2", "uncommitted count unused", busy, 0);
        chk(rd_data[3:0] == 4'hF, "R9", "all events in single frame", rd_data[3:0], 4'hF);

        // R10 clear all
        wr(3, 32'hFF0);
        chk(rd_data[3:0] == 0, "R10", "status cleared", rd_data[3:0], 0);

        // commit and run three frames; R4 restart attempt mid run
        wr(4, 1);
        wr(0, 0);
        wr(0, 1);
        frame(4);
        chk(busy == 1'b1, "R5", "still running after frame 1", busy, 1);
        chk(rd_data[2] == 1'b0, "R8", "marked frame not yet", rd_data[2], 0);
        wr(0, 0);
        wr(0, 1);
        frame(4);
        chk(rd_data[2] == 1'b1, "R8", "marked frame index 1", rd_data[2], 1);
        chk(rd_data[1] == 1'b0, "R7", "no display end yet", rd_data[1], 0);
        frame(4);
        chk(busy == 1'b0, "R4", "restart ignored, ends after 3 frames", busy, 0);
        chk(rd_data[1] == 1'b1, "R7", "display end", rd_data[1], 1);
        chk(rd_data[3] == 1'b1, "R9", "line flag at line 2", rd_data[3], 1);

        // R11 masking
        wr(3, 32'h000);
        chk(irq == 1'b1, "R11", "irq unmasked", irq, 1);
        wr(3, 32'h1E0);
        chk(irq == 1'b0, "R11", "only unmasked bit cleared", irq, 0);

        // R12 idle pulses ignored
        wr(3, 32'hF00);
        frame(3);
        chk(rd_data[3:0] == 0, "R12", "idle pulses ignored", rd_data[3:0], 0);
        chk(busy == 1'b0, "R12", "idle stays idle", busy, 0);

        // R3 go already 1, rewriting 1 starts nothing
        wr(0, 1);
        chk(busy == 1'b0, "R3", "held go no start", busy, 0);

        // R10 clear in same cycle as event
        wr(0, 0);
        wr(0, 1);
        frame(1);
        wr(3, 32'hF00);
        frame_end = 1'b1;
        wr(3, 32'h100);
        frame_end = 1'b0;
        chk(rd_data[0] == 1'b1, "R10", "event wins over clear", rd_data[0], 1);
        @(negedge clk);
        frame(2);
        chk(busy == 1'b0, "R5", "sequence finished", busy, 0);

        summary();
        $finish;
    end
endmodule